// File: doc/BRIEF.md
# Per-Hart Message-Signalled Interrupt File

This block holds the incoming message-signalled interrupts of one hart. A device raises an interrupt by writing an identity number into a doorbell register. That write sets the pending bit for the identity. Software reaches the pending bits, the enable bits, a threshold and a delivery switch through an indirect window. The window is a select register plus a data port that can write, set bits or clear bits on the selected 32-bit word.

A top-interrupt register reports the lowest-numbered identity that is both pending and enabled. Asserting the claim input clears the pending bit of that identity. This is the hardware side of the read-and-zero swap that software performs on the top-interrupt register. The external-interrupt output toward the hart is raised when delivery is switched on and the top identity passes the threshold.

Top module: `msi_intfile`

## Requirements
- R1: The select value chooses the register for `csr_rdata` and for data operations: 0x70 is delivery enable (bit 0), 0x72 is the threshold, 0x80+k is pending word k, and 0xC0+k is enable word k, for k < (NUM_IDS+1)/32. Any other select value reads zero, and writes to it change nothing.
- R2: Identity n lives in word n/32 at bit n mod 32 of both the pending array and the enable array.
- R3: Identity 0 is not implemented. Its pending and enable bits always read 0, and writes to them are dropped.
- R4: A doorbell write with `msi_be`=0 sets the pending bit of the identity given by `msi_data`.
- R5: A doorbell write with `msi_be`=1 byte-reverses `msi_data` before it is decoded as the identity.
- R6: A doorbell identity of 0, or an identity above NUM_IDS, leaves every pending bit unchanged.
- R7: `csr_op` encodings are 00 idle, 01 write, 10 set bits, 11 clear bits. Set and clear change only the bits that are 1 in `csr_wdata`.
- R8: `topei` carries the lowest nonzero identity that is both pending and enabled, in bits [26:16] and again in bits [10:0]. `topei` is 0 when no such identity exists.
- R9: `claim` clears the pending bit of the current top identity. A doorbell write to that same identity in the same cycle wins, and the bit stays set.
- R10: `ext_irq` is 1 exactly when delivery is 1, the top identity is nonzero, and either the threshold is 0 or the top identity is below the threshold. A threshold of 1 therefore blocks every identity.
- R11: After reset, all pending bits, enable bits, delivery, threshold and select are 0, and `ext_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_we | input | 1 | Doorbell write strobe |
| msi_be | input | 1 | Selects the big-endian doorbell (offset 0x04) instead of the little-endian one (offset 0x00) |
| msi_data | input | 32 | Doorbell write data (the identity) |
| sel_we | input | 1 | Loads the select register |
| sel_wdata | input | 8 | New select value |
| csr_op | input | 2 | Data operation on the selected word |
| csr_wdata | input | 32 | Operand of the data operation |
| csr_rdata | output | 32 | Current value of the selected word |
| claim | input | 1 | Claims (clears) the current top identity |
| topei | output | 32 | Top-interrupt value |
| ext_irq | output | 1 | External interrupt request to the hart |

## Verification
A table of doorbell writes mixes several kinds of identity. Some are in range, some are zero, some are above the limit, and some are byte-reversed. After each write the reported top identity is checked. This separates a correct priority choice from decoding or endianness errors.

Repeated claims drain the pending set in ascending order, which tests the lowest-identity rule. A claim that coincides with a new doorbell write to the same identity tests which of the two wins. Threshold values of 0, 1, 2 and the top identity itself bracket the strict less-than comparison. Word readback after masked set and clear operations shows the identity-to-bit mapping and that untouched bits are preserved.

// File: rtl/msi_intfile.sv
module msi_intfile #(
  parameter int NUM_IDS = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        msi_we,
  input  logic        msi_be,
  input  logic [31:0] msi_data,
  input  logic        sel_we,
  input  logic [7:0]  sel_wdata,
  input  logic [1:0]  csr_op,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  input  logic        claim,
  output logic [31:0] topei,
  output logic        ext_irq
);
  localparam int NW  = (NUM_IDS + 1) / 32;
  localparam int NB  = NW * 32;
  localparam int IDW = $clog2(NUM_IDS + 1);

  logic [NB-1:0]  pend_q, en_q, pend_d, en_d;
  logic           dlv_q, dlv_d;
  logic [IDW-1:0] thr_q, thr_d, top;
  logic [7:0]     sel_q;
  logic [31:0]    msi_id, cur_word, new_word;
  logic           msi_ok;

  assign msi_id = msi_be ? {msi_data[7:0], msi_data[15:8], msi_data[23:16], msi_data[31:24]}
                         : msi_data;
  assign msi_ok = msi_we && (msi_id != 32'd0) && (msi_id <= 32'(NUM_IDS));

  always_comb begin
    cur_word = '0;
    if (sel_q == 8'h70)      cur_word = {31'b0, dlv_q};
    else if (sel_q == 8'h72) cur_word = 32'(thr_q);
    else begin
      for (int w = 0; w < NW; w++) begin
        if (sel_q == 8'(8'h80 + w)) cur_word = pend_q[w*32 +: 32];
        if (sel_q == 8'(8'hC0 + w)) cur_word = en_q[w*32 +: 32];
      end
    end
  end

  assign csr_rdata = cur_word;

  always_comb begin
    case (csr_op)
      2'b01:   new_word = csr_wdata;
      2'b10:   new_word = cur_word | csr_wdata;
      2'b11:   new_word = cur_word & ~csr_wdata;
      default: new_word = cur_word;
    endcase
  end

  always_comb begin
    top = '0;
    for (int i = NUM_IDS; i >= 1; i--)
      if (pend_q[i] && en_q[i]) top = IDW'(i);
  end

  always_comb begin
    pend_d = pend_q;
    en_d   = en_q;
    dlv_d  = dlv_q;
    thr_d  = thr_q;
    if (csr_op != 2'b00) begin
      if (sel_q == 8'h70) dlv_d = new_word[0];
      if (sel_q == 8'h72) thr_d = new_word[IDW-1:0];
      for (int w = 0; w < NW; w++) begin
        if (sel_q == 8'(8'h80 + w)) pend_d[w*32 +: 32] = new_word;
        if (sel_q == 8'(8'hC0 + w)) en_d[w*32 +: 32]   = new_word;
      end
    end
    if (claim && top != '0) pend_d[top] = 1'b0;
    if (msi_ok) pend_d[msi_id[IDW-1:0]] = 1'b1;
    pend_d[0] = 1'b0;
    en_d[0]   = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
      dlv_q  <= 1'b0;
      thr_q  <= '0;
      sel_q  <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      dlv_q  <= dlv_d;
      thr_q  <= thr_d;
      if (sel_we) sel_q <= sel_wdata;
    end
  end

  assign topei   = {5'b0, 11'(top), 5'b0, 11'(top)};
  assign ext_irq = dlv_q && (top != '0) && ((thr_q == '0) || (top < thr_q));
endmodule

// File: rtl/msi_intfile_chk.sv
module msi_intfile_chk #(
  parameter int NUM_IDS = 63
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   msi_we,
  input logic                   msi_be,
  input logic [31:0]            msi_data,
  input logic [1:0]             csr_op,
  input logic                   claim,
  input logic [31:0]            topei,
  input logic                   ext_irq,
  input logic [NUM_IDS:0]       pend_q,
  input logic                   dlv_q,
  input logic [$clog2(NUM_IDS+1)-1:0] thr_q
);
  localparam int IDW = $clog2(NUM_IDS + 1);

  logic [31:0]    raw_c;
  logic           ok_c;
  logic [IDW-1:0] id_c, tid_c;

  assign raw_c = msi_be ? {msi_data[7:0], msi_data[15:8], msi_data[23:16], msi_data[31:24]} : msi_data;
  assign ok_c  = msi_we && raw_c != 0 && raw_c <= 32'(NUM_IDS);
  assign id_c  = raw_c[IDW-1:0];
  assign tid_c = topei[IDW-1:0];

  AST_EXT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> (dlv_q && topei[26:16] != 11'd0)); // R10
  AST_THR_ONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q == IDW'(1)) |-> !ext_irq); // R10
  AST_MSI_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ok_c |=> pend_q[$past(id_c)]); // R4
  AST_BAD_ID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_we && !ok_c && csr_op == 2'b00 && !claim) |=> pend_q == $past(pend_q)); // R6
  AST_CLAIM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && tid_c != '0 && csr_op == 2'b00 && !(ok_c && id_c == tid_c)) |=> !pend_q[$past(tid_c)]); // R9
endmodule

bind msi_intfile msi_intfile_chk #(.NUM_IDS(NUM_IDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .msi_we(msi_we), .msi_be(msi_be), .msi_data(msi_data),
  .csr_op(csr_op), .claim(claim), .topei(topei), .ext_irq(ext_irq),
  .pend_q(pend_q), .dlv_q(dlv_q), .thr_q(thr_q)
);

// File: tb/test_msi_intfile.sv
module test_msi_intfile;
  logic        clk = 0, rst_n = 0;
  logic        msi_we = 0, msi_be = 0, sel_we = 0, claim = 0;
  logic [31:0] msi_data = 0, csr_wdata = 0;
  logic [7:0]  sel_wdata = 0;
  logic [1:0]  csr_op = 0;
  logic [31:0] csr_rdata, topei;
  logic        ext_irq;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  msi_intfile #(.NUM_IDS(63)) i_msi_intfile (
    .clk(clk), .rst_n(rst_n), .msi_we(msi_we), .msi_be(msi_be), .msi_data(msi_data),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .csr_op(csr_op), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .claim(claim), .topei(topei), .ext_irq(ext_irq));

  // {big-endian, doorbell data, expected top identity}
  localparam logic [43:0] VEC [8] = '{
    {1'b0, 32'd40,        11'd40},
    {1'b0, 32'd70,        11'd40},
    {1'b0, 32'd0,         11'd40},
    {1'b0, 32'd33,        11'd33},
    {1'b1, 32'h0500_0000, 11'd5},
    {1'b0, 32'd63,        11'd5},
    {1'b1, 32'h0000_0002, 11'd5},
    {1'b0, 32'd1,         11'd1}
  };

  function automatic logic [31:0] tv(input int id);
    return (32'(id) << 16) | 32'(id);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    msi_we = 0; sel_we = 0; csr_op = 0; claim = 0;
    #1;
  endtask

  task automatic sel(input logic [7:0] a);
    @(negedge clk); sel_we = 1; sel_wdata = a; step();
  endtask

  task automatic op(input logic [1:0] o, input logic [31:0] d);
    @(negedge clk); csr_op = o; csr_wdata = d; step();
  endtask

  task automatic doorbell(input logic be, input logic [31:0] d);
    @(negedge clk); msi_we = 1; msi_be = be; msi_data = d; step();
  endtask

  task automatic do_claim;
    @(negedge clk); claim = 1; step();
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    check("R11 topei", topei, 0);
    check("R11 ext", {31'b0, ext_irq}, 0);
    check("R11 sel0 read", csr_rdata, 0);
    sel(8'h70);
    check("R11 delivery", csr_rdata, 0);

    sel(8'hC0); op(2'b10, 32'hFFFF_FFFF);
    check("R3 en word0 id0", csr_rdata, 32'hFFFF_FFFE);
    sel(8'hC1); op(2'b10, 32'hFFFF_FFFF);
    check("R1 en word1", csr_rdata, 32'hFFFF_FFFF);

    for (int k = 0; k < 8; k++) begin
      doorbell(VEC[k][43], VEC[k][42:11]);
      check("R4 R5 R6 R8 table", topei, tv(int'(VEC[k][10:0])));
    end

    sel(8'h80);
    check("R2 pend word0", csr_rdata, 32'h0000_0022);
    sel(8'h81);
    check("R2 pend word1", csr_rdata, 32'h8000_0102);

    check("R10 delivery off", {31'b0, ext_irq}, 0);
    sel(8'h70); op(2'b01, 32'd1);
    check("R10 delivery on", {31'b0, ext_irq}, 1);
    sel(8'h72); op(2'b01, 32'd1);
    check("R10 thr1 blocks", {31'b0, ext_irq}, 0);
    op(2'b01, 32'd2);
    check("R10 thr2 passes id1", {31'b0, ext_irq}, 1);
    op(2'b01, 32'd0);
    check("R10 thr0 no limit", {31'b0, ext_irq}, 1);

    sel(8'hC0); op(2'b11, 32'h0000_0002);
    check("R7 clear mask", csr_rdata, 32'hFFFF_FFFC);
    check("R8 masked id1", topei, tv(5));
    op(2'b10, 32'h0000_0002);
    check("R7 set mask", csr_rdata, 32'hFFFF_FFFE);

    begin
      int order [5] = '{1, 5, 33, 40, 63};
      for (int k = 0; k < 5; k++) begin
        check("R9 claim order", topei, tv(order[k]));
        do_claim();
      end
    end
    check("R8 empty", topei, 0);
    check("R10 empty ext", {31'b0, ext_irq}, 0);

    doorbell(1'b0, 32'd9);
    @(negedge clk); claim = 1; msi_we = 1; msi_be = 0; msi_data = 32'd9; step();
    check("R9 msi wins", topei, tv(9));
    do_claim();
    check("R9 claim clears", topei, 0);

    sel(8'h80); op(2'b01, 32'hFFFF_FFFF);
    check("R3 id0 write", csr_rdata, 32'hFFFF_FFFE);
    check("R8 after write", topei, tv(1));
    op(2'b01, 32'd0);
    check("R7 write clears", topei, 0);

    sel(8'hC2); op(2'b01, 32'hFFFF_FFFF);
    check("R1 unimplemented", csr_rdata, 0);

    sel(8'h72); op(2'b01, 32'd63);
    doorbell(1'b0, 32'd63);
    check("R10 thr equal blocks", {31'b0, ext_irq}, 0);
    check("R8 top63", topei, tv(63));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule